// File: doc/BRIEF.md
# BAR Mapping Validity Decoder

This block sits beside a device's configuration register file. It takes the enable bits of the command register and the stored words of up to a parameterised number of base address registers, plus one expansion ROM register. For each region it decides whether the region is mapped, and if so at which aligned base and which last address. The size and the address space (I/O or memory) of each region are fixed by parameters. Region words are presented as one flat vector. Region `r` occupies bits `[32*r+31:32*r]`, and the highest region index is always the expansion ROM.

Nothing is recomputed until the register file pulses the update input. The new mapping is held from the following cycle. A one-cycle changed flag is raised for every region whose mapping appears, disappears or moves, so a downstream decoder can re-route traffic. A combinational hit vector tells which mapped region claims an incoming I/O or memory address.

Top module: `bar_map_decoder`

## Requirements
- R1: After synchronous reset, every region reports not valid, base and last zero, no changed flag and no hit.
- R2: An I/O region (space bit 1) is valid only while the I/O enable is 1. Its base is the region word with the low log2(size) bits cleared. Its last address is base + size − 1. A region that is not valid reports base 0 and last 0.
- R3: A memory region (space bit 0) is valid only while the memory enable is 1, independent of the I/O enable.
- R4: The expansion ROM region (highest index) is valid only when, in addition to the memory enable, bit 0 of its word is 1.
- R5: A region whose aligned base is zero is not valid.
- R6: A memory region whose last address is all ones, or whose last address is not above its base, is not valid.
- R7: An I/O region is valid only when its last address is below 0x10000.
- R8: A region with size parameter 0 is never valid and never raises its changed flag.
- R9: Held mappings change only in the cycle after an update pulse. Input changes without a pulse have no effect on any output.
- R10: After an update pulse, a region's changed flag is 1 for exactly one cycle if its validity changed, or if it stays valid with a different base. Otherwise the flag stays 0.
- R11: The hit bit of a region is 1 exactly when the region is valid, the access space bit equals the region's space, and base ≤ address ≤ last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| update_i | input | 1 | One-cycle pulse: recompute all mappings |
| io_enable_i | input | 1 | Command register I/O space enable |
| mem_enable_i | input | 1 | Command register memory space enable |
| region_words_i | input | 32*(NUM_BARS+1) | Stored BAR words; top slice is the ROM register |
| acc_addr_i | input | 32 | Address of an incoming access |
| acc_is_io_i | input | 1 | Access space: 1 = I/O, 0 = memory |
| map_valid_o | output | NUM_BARS+1 | Region currently mapped |
| map_base_o | output | 32*(NUM_BARS+1) | Held aligned base per region |
| map_last_o | output | 32*(NUM_BARS+1) | Held last address per region |
| map_changed_o | output | NUM_BARS+1 | One-cycle pulse when a mapping appears, disappears or moves |
| acc_hit_o | output | NUM_BARS+1 | Region claims the current access |

## Verification
The bench builds the block with three BARs plus the ROM, four regions in all. Region 0 is a 16-byte I/O window, region 1 is a 4 KiB memory window, region 2 has size zero, and the ROM spans 2 KiB. This one configuration covers both enable bits, the ROM enable bit, the 64K I/O ceiling at its exact edge, and the all-ones memory top. It also shows that an unused region stays silent while its neighbours move. The small sizes let hit checks reach both ends of each window and the addresses just outside them.

// File: rtl/bar_map_pkg.sv
package bar_map_pkg;

    localparam int ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    // First I/O address outside the 64K port space
    localparam addr_t IO_SPACE_END = 32'h0001_0000;

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    typedef struct packed {
        logic  ok;
        addr_t base;
        addr_t last;
    } region_map_t;

    function automatic addr_t align_mask(input addr_t size);
        return ~(size - addr_t'(1));
    endfunction

    function automatic logic range_ok(input addr_t base, input addr_t last,
                                      input space_e space);
        logic top_ok;
        top_ok = (space == SPACE_IO) ? (last < IO_SPACE_END) : (last != '1);
        return (last > base) && (base != '0) && top_ok;
    endfunction

endpackage

// File: rtl/bar_region_eval.sv
module bar_region_eval
    import bar_map_pkg::*;
#(
    parameter addr_t  SIZE   = 32'h1000,
    parameter space_e SPACE  = SPACE_MEM,
    parameter bit     IS_ROM = 1'b0
) (
    input  addr_t       word_i,
    input  logic        io_en_i,
    input  logic        mem_en_i,
    output region_map_t calc_o
);
    addr_t base_c;
    addr_t last_c;
    logic  space_en_c;
    logic  rom_en_c;

    always_comb begin
        base_c     = word_i & align_mask(SIZE);
        last_c     = base_c + SIZE - addr_t'(1);
        space_en_c = (SPACE == SPACE_IO) ? io_en_i : mem_en_i;
        rom_en_c   = IS_ROM ? word_i[0] : 1'b1;
        calc_o.ok   = (SIZE != '0) && space_en_c && rom_en_c
                      && range_ok(base_c, last_c, SPACE);
        calc_o.base = base_c;
        calc_o.last = last_c;
    end
endmodule

// File: rtl/bar_region_hold.sv
module bar_region_hold
    import bar_map_pkg::*;
#(
    parameter addr_t  SIZE  = 32'h1000,
    parameter space_e SPACE = SPACE_MEM
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        upd_i,
    input  region_map_t calc_i,
    input  addr_t       acc_addr_i,
    input  logic        acc_is_io_i,
    output logic        valid_o,
    output addr_t       base_o,
    output addr_t       last_o,
    output logic        changed_o,
    output logic        hit_o
);
    logic  valid_q;
    addr_t base_q;
    addr_t last_q;
    logic  chg_q;
    logic  differs_c;

    assign differs_c = (calc_i.ok != valid_q) || (calc_i.ok && (calc_i.base != base_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            base_q  <= '0;
            last_q  <= '0;
            chg_q   <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (upd_i && differs_c) begin
                valid_q <= calc_i.ok;
                base_q  <= calc_i.ok ? calc_i.base : '0;
                last_q  <= calc_i.ok ? calc_i.last : '0;
                chg_q   <= 1'b1;
            end
        end
    end

    always_comb begin
        hit_o = valid_q && (acc_is_io_i == (SPACE == SPACE_IO))
                && (acc_addr_i >= base_q) && (acc_addr_i <= last_q);
    end

    assign valid_o   = valid_q;
    assign base_o    = base_q;
    assign last_o    = last_q;
    assign changed_o = chg_q;

    p_changed_after_update_r10: assert property (@(posedge clk) disable iff (rst)
        chg_q |-> $past(upd_i));
    p_changed_single_r10: assert property (@(posedge clk) disable iff (rst)
        chg_q |=> !chg_q || $past(upd_i));
    p_hold_without_update_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(valid_q) && $stable(base_q) && $stable(last_q));
    p_nonzero_base_r5: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> base_q != '0);
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> last_q > base_q);
    p_hit_in_window_r11: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> valid_q && acc_addr_i >= base_q && acc_addr_i <= last_q);

    if (SPACE == SPACE_IO) begin : g_io_chk
        p_io_below_64k_r7: assert property (@(posedge clk) disable iff (rst)
            valid_q |-> last_q < IO_SPACE_END);
    end else begin : g_mem_chk
        p_mem_not_top_r6: assert property (@(posedge clk) disable iff (rst)
            valid_q |-> last_q != '1);
    end

    if (SIZE == '0) begin : g_empty_chk
        p_empty_region_r8: assert property (@(posedge clk) disable iff (rst)
            !valid_q && !chg_q);
    end
endmodule

// File: rtl/bar_map_decoder.sv
module bar_map_decoder
    import bar_map_pkg::*;
#(
    parameter int NUM_BARS = 6,
    parameter logic [(NUM_BARS+1)*32-1:0] REGION_SIZE = {
        32'h0001_0000, 32'h0000_0010, 32'h0000_0100, 32'h0000_0000,
        32'h0010_0000, 32'h0000_1000, 32'h0000_0020},
    parameter logic [NUM_BARS:0] REGION_IO = 7'b001_0001
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          update_i,
    input  logic                          io_enable_i,
    input  logic                          mem_enable_i,
    input  logic [(NUM_BARS+1)*32-1:0]    region_words_i,
    input  logic [31:0]                   acc_addr_i,
    input  logic                          acc_is_io_i,
    output logic [NUM_BARS:0]             map_valid_o,
    output logic [(NUM_BARS+1)*32-1:0]    map_base_o,
    output logic [(NUM_BARS+1)*32-1:0]    map_last_o,
    output logic [NUM_BARS:0]             map_changed_o,
    output logic [NUM_BARS:0]             acc_hit_o
);
    localparam int NREG    = NUM_BARS + 1;
    localparam int ROM_IDX = NREG - 1;

    for (genvar r = 0; r < NREG; r++) begin : g_region
        localparam addr_t  SZ     = REGION_SIZE[r*ADDR_W +: ADDR_W];
        localparam space_e SP     = (REGION_IO[r] && r != ROM_IDX) ? SPACE_IO : SPACE_MEM;
        localparam bit     IS_ROM = (r == ROM_IDX);

        region_map_t calc;

        bar_region_eval #(.SIZE(SZ), .SPACE(SP), .IS_ROM(IS_ROM)) u_eval (
            .word_i   (region_words_i[r*ADDR_W +: ADDR_W]),
            .io_en_i  (io_enable_i),
            .mem_en_i (mem_enable_i),
            .calc_o   (calc)
        );

        bar_region_hold #(.SIZE(SZ), .SPACE(SP)) u_hold (
            .clk         (clk),
            .rst         (rst),
            .upd_i       (update_i),
            .calc_i      (calc),
            .acc_addr_i  (acc_addr_i),
            .acc_is_io_i (acc_is_io_i),
            .valid_o     (map_valid_o[r]),
            .base_o      (map_base_o[r*ADDR_W +: ADDR_W]),
            .last_o      (map_last_o[r*ADDR_W +: ADDR_W]),
            .changed_o   (map_changed_o[r]),
            .hit_o       (acc_hit_o[r])
        );

        if (SP == SPACE_IO) begin : g_io_en_chk
            p_io_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
                $rose(map_valid_o[r]) |-> $past(io_enable_i));
        end else begin : g_mem_en_chk
            p_mem_needs_enable_r3: assert property (@(posedge clk) disable iff (rst)
                $rose(map_valid_o[r]) |-> $past(mem_enable_i));
        end

        if (IS_ROM) begin : g_rom_chk
            p_rom_needs_bit0_r4: assert property (@(posedge clk) disable iff (rst)
                $rose(map_valid_o[r]) |-> $past(region_words_i[r*ADDR_W]));
        end
    end

    p_changed_subset_r10: assert property (@(posedge clk) disable iff (rst)
        (map_changed_o != '0) |-> $past(update_i));
endmodule

// File: tb/bar_map_decoder_bench.sv
`timescale 1ns/1ps
module bar_map_decoder_bench;
    localparam int NB = 3;
    localparam int NR = NB + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd = 1'b0;
    logic io_en = 1'b0;
    logic mem_en = 1'b0;
    logic [NR*32-1:0] words = '0;
    logic [31:0] acc_addr = '0;
    logic acc_io = 1'b0;
    logic [NR-1:0] valid, changed, hit;
    logic [NR*32-1:0] base, last;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bar_map_decoder #(
        .NUM_BARS(NB),
        .REGION_SIZE({32'h0000_0800, 32'h0000_0000, 32'h0000_1000, 32'h0000_0010}),
        .REGION_IO(4'b0001)
    ) u_bar_map_decoder (
        .clk(clk), .rst(rst), .update_i(upd),
        .io_enable_i(io_en), .mem_enable_i(mem_en),
        .region_words_i(words), .acc_addr_i(acc_addr), .acc_is_io_i(acc_io),
        .map_valid_o(valid), .map_base_o(base), .map_last_o(last),
        .map_changed_o(changed), .acc_hit_o(hit)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_word(input int r, input logic [31:0] v);
        words[r*32 +: 32] = v;
    endtask

    // Drive an update pulse, then sample one negedge later
    task automatic pulse_update();
        @(negedge clk);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic check_region(input string req, input int r, input logic v,
                                input logic [31:0] b, input logic [31:0] l);
        check(req, $sformatf("valid[%0d]", r), 64'(valid[r]), 64'(v));
        check(req, $sformatf("base[%0d]", r), 64'(base[r*32 +: 32]), 64'(b));
        check(req, $sformatf("last[%0d]", r), 64'(last[r*32 +: 32]), 64'(l));
    endtask

    task automatic t_reset();
        acc_addr = 32'h0; acc_io = 1'b1;
        #1;
        check("R1", "valid", 64'(valid), 64'h0);
        check("R1", "changed", 64'(changed), 64'h0);
        check("R1", "hit", 64'(hit), 64'h0);
        check("R1", "base", 64'(base[63:0]), 64'h0);
    endtask

    task automatic t_io_only();
        io_en = 1'b1; mem_en = 1'b0;
        set_word(0, 32'h0000_C001);
        set_word(1, 32'h8000_0000);
        set_word(3, 32'h000E_0001);
        pulse_update();
        check_region("R2", 0, 1'b1, 32'h0000_C000, 32'h0000_C00F);
        check_region("R3", 1, 1'b0, 32'h0, 32'h0);
        check_region("R4", 3, 1'b0, 32'h0, 32'h0);
        check("R10", "changed", 64'(changed), 64'h1);
        @(negedge clk);
        check("R10", "changed one cycle", 64'(changed), 64'h0);
    endtask

    task automatic t_mem_on();
        mem_en = 1'b1;
        pulse_update();
        check_region("R3", 1, 1'b1, 32'h8000_0000, 32'h8000_0FFF);
        check_region("R4", 3, 1'b1, 32'h000E_0000, 32'h000E_07FF);
        check("R10", "changed no io move", 64'(changed), 64'hA);
    endtask

    task automatic t_rom_bit();
        set_word(3, 32'h000E_0000);
        pulse_update();
        check_region("R4", 3, 1'b0, 32'h0, 32'h0);
        check("R10", "rom gone", 64'(changed), 64'h8);
    endtask

    task automatic t_move();
        set_word(1, 32'h9000_0123);
        pulse_update();
        check_region("R10", 1, 1'b1, 32'h9000_0000, 32'h9000_0FFF);
        check("R10", "moved", 64'(changed), 64'h2);
        pulse_update();
        check("R10", "same again", 64'(changed), 64'h0);
    endtask

    task automatic t_no_update();
        set_word(0, 32'h0000_D000);
        set_word(1, 32'hA000_0000);
        io_en = 1'b0;
        repeat (3) @(negedge clk);
        check_region("R9", 0, 1'b1, 32'h0000_C000, 32'h0000_C00F);
        check_region("R9", 1, 1'b1, 32'h9000_0000, 32'h9000_0FFF);
        check("R9", "changed", 64'(changed), 64'h0);
        io_en = 1'b1;
    endtask

    task automatic t_limits();
        set_word(0, 32'h0000_FFF1);
        pulse_update();
        check_region("R7", 0, 1'b1, 32'h0000_FFF0, 32'h0000_FFFF);
        set_word(0, 32'h0001_0001);
        pulse_update();
        check_region("R7", 0, 1'b0, 32'h0, 32'h0);
        set_word(0, 32'h0000_C000);
        pulse_update();
        set_word(0, 32'h0000_000D);
        pulse_update();
        check_region("R5", 0, 1'b0, 32'h0, 32'h0);
        set_word(1, 32'hFFFF_F000);
        pulse_update();
        check_region("R6", 1, 1'b0, 32'h0, 32'h0);
        set_word(1, 32'h0000_0FFF);
        pulse_update();
        check_region("R5", 1, 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_empty();
        set_word(2, 32'h4000_0000);
        mem_en = 1'b1;
        pulse_update();
        check_region("R8", 2, 1'b0, 32'h0, 32'h0);
        check("R8", "changed[2]", 64'(changed[2]), 64'h0);
    endtask

    task automatic t_hit();
        set_word(0, 32'h0000_C000);
        set_word(1, 32'h8000_0000);
        pulse_update();
        acc_io = 1'b1; acc_addr = 32'h0000_C00F; #1;
        check("R11", "io last", 64'(hit), 64'h1);
        acc_addr = 32'h0000_C010; #1;
        check("R11", "io past end", 64'(hit), 64'h0);
        acc_addr = 32'h0000_BFFF; #1;
        check("R11", "io before base", 64'(hit), 64'h0);
        acc_io = 1'b0; acc_addr = 32'h8000_0000; #1;
        check("R11", "mem base", 64'(hit), 64'h2);
        acc_addr = 32'h0000_C005; #1;
        check("R11", "space mismatch", 64'(hit), 64'h0);
        acc_io = 1'b1; acc_addr = 32'h8000_0010; #1;
        check("R11", "io addr in mem window", 64'(hit), 64'h0);
    endtask

    task automatic t_io_off();
        io_en = 1'b0;
        pulse_update();
        check_region("R2", 0, 1'b0, 32'h0, 32'h0);
        check("R10", "io gone", 64'(changed), 64'h1);
        acc_addr = 32'h0000_C000; acc_io = 1'b1; #1;
        check("R11", "disabled io", 64'(hit), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_io_only();
        t_mem_on();
        t_rom_bit();
        t_move();
        t_no_update();
        t_limits();
        t_empty();
        t_hit();
        t_io_off();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule